// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current in one motor winding by switching its bridge on and off. A comparator flag, which comes from outside the clock domain and goes high when the sensed winding current is above the reference, is synchronized through two flops. While the bridge is on, a synchronized high flag ends the on interval. The bridge then stays off for a fixed number of clock cycles, taken from a configuration input at the moment of the chop, and for a further dead-time interval. After that it turns back on. The length of the off interval is fixed and the switching period is not: it depends on how quickly the current rises again.

Each on interval starts with a blanking window. During that window the comparator is ignored, so that the recovery spike that follows turn-on cannot end the interval early. A minimum on time applies as well, so the bridge never stays on for less than a set number of cycles. An enable input stops the regulator: the bridge request drops and all timers clear. When enable returns, the regulator starts a new on interval at once. A one-cycle chop pulse marks each comparator-driven turn-off.

Top module: `toff_chopper`

## Requirements
- R1: While reset is high, and on the first cycle after it, `bridge_on_o` and `chop_o` are 0, whatever the levels on `en` and `cmp_async`.
- R2: If `en` is 0 at a rising edge, `bridge_on_o` and `chop_o` are 0 after that edge. They stay 0 while `en` is low, even with the comparator held high.
- R3: If `en` is sampled high at an edge while the block is idle, `bridge_on_o` goes to 1 after that same edge.
- R4: The comparator is seen through a two-flop synchronizer. When the bridge is on and past its blanking and minimum on time, a `cmp_async` level that is high from just after edge 0 makes `bridge_on_o` fall after edge 3, and not before.
- R5: During the first BLANK_CYC cycles of each on interval (default 4), comparator activity has no effect. A comparator pulse that reaches the synchronized side only inside that window does not end the interval.
- R6: An on interval always lasts at least MIN_ON_CYC cycles (default 10). With the comparator held high all the time, every on interval lasts exactly max(BLANK_CYC+1, MIN_ON_CYC) = 10 cycles.
- R7: After a chop, `bridge_on_o` stays 0 for exactly L + DEAD_CYC cycles, where L is `off_len_cfg` sampled at the chop edge and DEAD_CYC defaults to 3. An L of 0 is treated as 1.
- R8: When the off interval ends, the bridge turns on again and blanking restarts. With the comparator held high, the output repeats a fixed on/off pattern.
- R9: `chop_o` is a one-cycle pulse. It is high exactly in the first cycle after a comparator-driven fall of `bridge_on_o`, and never while the bridge is on.
- R10: Taking `en` low during an off interval abandons that interval. On re-enable, the bridge turns on after the first edge at which `en` is sampled high, without waiting for the rest of the off time.
- R11: A change on `off_len_cfg` after the chop edge has no effect on the off interval that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable; low forces the bridge off and clears timers |
| cmp_async | input | 1 | Unsynchronized comparator flag, high when current exceeds reference |
| off_len_cfg | input | CNT_W (32) | Off time in clock cycles, sampled at each chop |
| bridge_on_o | output | 1 | Registered bridge-on request to the gate logic |
| chop_o | output | 1 | One-cycle pulse at each comparator-driven turn-off |

## Verification
The regulator's phase and its three counters show at the ports only through the timing of `bridge_on_o` edges. If the phase is wrong, the bridge sticks on or off, and this shows within one on/off period. If a counter is off by one, an edge moves by a single cycle at the next chop, or at the next return to on. The bench therefore measures the exact high and low run lengths, in cycles, under held, late and short comparator stimulus. It also measures the synchronizer latency edge by edge, so any extra or missing register stage shows as a one-cycle shift.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2,
    PH_DEAD = 2'd3
  } chop_phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/chop_on_timer.sv
module chop_on_timer #(
  parameter int GATE_CYC = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic armed
);

  localparam int CW = $clog2(GATE_CYC + 2);
  localparam logic [CW-1:0] GATE_V = CW'(GATE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (cnt != GATE_V) cnt <= cnt + 1'b1;
  end

  assign armed = (cnt == GATE_V);

  // R6
  armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !clr |=> armed);

endmodule

// File: rtl/chop_down_cnt.sv
module chop_down_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= W'(1));

endmodule

// File: rtl/toff_chopper.sv
module toff_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int BLANK_CYC  = 4,
  parameter int MIN_ON_CYC = 10,
  parameter int DEAD_CYC   = 3,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cmp_async,
  input  logic [CNT_W-1:0] off_len_cfg,
  output logic             bridge_on_o,
  output logic             chop_o
);

  localparam int GATE_CYC = imax(BLANK_CYC, MIN_ON_CYC - 1);
  localparam int DEAD_W   = $clog2(DEAD_CYC + 1);
  localparam int RUN_MAX  = imax(MIN_ON_CYC, BLANK_CYC);
  localparam int RUN_W    = $clog2(RUN_MAX + 2);

  chop_phase_t ph, nxt;
  logic cmp_s, armed, off_last, dead_last;
  logic chop, to_dead;

  chop_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_async), .q(cmp_s)
  );

  chop_on_timer #(.GATE_CYC(GATE_CYC)) u_on (
    .clk(clk), .rst(rst), .clr(ph != PH_ON), .armed(armed)
  );

  assign chop    = (ph == PH_ON) && en && armed && cmp_s;
  assign to_dead = (ph == PH_OFF) && en && off_last;

  chop_down_cnt #(.W(CNT_W)) u_off (
    .clk(clk), .rst(rst), .clr(!en), .load(chop),
    .load_val(off_len_cfg), .dec(ph == PH_OFF), .last(off_last)
  );

  chop_down_cnt #(.W(DEAD_W)) u_dead (
    .clk(clk), .rst(rst), .clr(!en), .load(to_dead),
    .load_val(DEAD_W'(DEAD_CYC)), .dec(ph == PH_DEAD), .last(dead_last)
  );

  always_comb begin
    nxt = ph;
    if (!en) nxt = PH_IDLE;
    else begin
      case (ph)
        PH_IDLE: nxt = PH_ON;
        PH_ON:   if (chop)      nxt = PH_OFF;
        PH_OFF:  if (off_last)  nxt = PH_DEAD;
        PH_DEAD: if (dead_last) nxt = PH_ON;
        default: nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_IDLE;
      bridge_on_o <= 1'b0;
      chop_o      <= 1'b0;
    end else begin
      ph          <= nxt;
      bridge_on_o <= (nxt == PH_ON);
      chop_o      <= chop;
    end
  end

  // Length of the current high run of the output, for the checks below
  logic [RUN_W-1:0] on_run;
  always_ff @(posedge clk) begin
    if (rst || !bridge_on_o)         on_run <= '0;
    else if (on_run != RUN_W'(RUN_MAX)) on_run <= on_run + 1'b1;
  end

  // R9
  chop_fall_chk: assert property (@(posedge clk) disable iff (rst)
    chop_o |-> !bridge_on_o && $past(bridge_on_o));

  // R2
  idle_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !bridge_on_o && !chop_o);

  // R6
  min_on_chk: assert property (@(posedge clk) disable iff (rst)
    chop_o |-> on_run >= RUN_W'(MIN_ON_CYC));

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    bridge_on_o && on_run < RUN_W'(BLANK_CYC) |=> !chop_o);

  // R4
  cmp_need_chk: assert property (@(posedge clk) disable iff (rst)
    chop_o |-> $past(cmp_s));

endmodule

// File: tb/toff_chopper_tb.sv
module toff_chopper_tb;

  localparam int DEAD = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cmp_async = 1'b0;
  logic [31:0] off_len_cfg = 32'd20;
  logic        bridge_on_o, chop_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  toff_chopper u_dut (
    .clk(clk), .rst(rst), .en(en), .cmp_async(cmp_async),
    .off_len_cfg(off_len_cfg), .bridge_on_o(bridge_on_o), .chop_o(chop_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic count_until(input logic val, input int limit, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (bridge_on_o !== val && n < limit);
  endtask

  task automatic t_reset();
    en = 1'b1; cmp_async = 1'b1; rst = 1'b1;
    tick(); tick();
    check(bridge_on_o === 1'b0 && chop_o === 1'b0, "R1 in reset", bridge_on_o, 0);
    en = 1'b0; cmp_async = 1'b0;
    tick();
    rst = 1'b0;
    tick();
    check(bridge_on_o === 1'b0 && chop_o === 1'b0, "R1 after reset", bridge_on_o, 0);
  endtask

  task automatic t_enable();
    en = 1'b1;
    check(bridge_on_o === 1'b0, "R3 before edge", bridge_on_o, 0);
    tick();
    check(bridge_on_o === 1'b1, "R3 on after enable", bridge_on_o, 1);
  endtask

  task automatic t_late_cmp();
    int n;
    repeat (15) tick();
    off_len_cfg = 32'd20; cmp_async = 1'b1;
    tick();
    check(bridge_on_o === 1'b1, "R4 edge1 still on", bridge_on_o, 1);
    tick();
    check(bridge_on_o === 1'b1, "R4 edge2 still on", bridge_on_o, 1);
    tick();
    check(bridge_on_o === 1'b0, "R4 off at edge3", bridge_on_o, 0);
    check(chop_o === 1'b1, "R9 chop pulse", chop_o, 1);
    off_len_cfg = 32'd50; cmp_async = 1'b0;
    tick();
    check(chop_o === 1'b0, "R9 single cycle", chop_o, 0);
    count_until(1'b1, 200, n);
    check(n + 1 == 20 + DEAD, "R7 R11 off length", n + 1, 20 + DEAD);
  endtask

  task automatic t_min_on();
    int n;
    off_len_cfg = 32'd5; cmp_async = 1'b1;
    count_until(1'b0, 100, n);
    count_until(1'b1, 100, n);
    check(n == 5 + DEAD, "R7 off length 5", n, 5 + DEAD);
    count_until(1'b0, 100, n);
    check(n == 10, "R6 min on held high", n, 10);
    count_until(1'b1, 100, n);
    check(n == 5 + DEAD, "R8 repeat off", n, 5 + DEAD);
    count_until(1'b0, 100, n);
    check(n == 10, "R8 repeat on", n, 10);
  endtask

  task automatic t_zero_off();
    int n;
    off_len_cfg = 32'd0; cmp_async = 1'b0;
    count_until(1'b1, 100, n);
    cmp_async = 1'b1;
    count_until(1'b0, 100, n);
    cmp_async = 1'b0;
    count_until(1'b1, 100, n);
    check(n == 1 + DEAD, "R7 zero off length", n, 1 + DEAD);
  endtask

  task automatic t_blank();
    int bad = 0;
    en = 1'b0;
    tick();
    en = 1'b1;
    tick();
    check(bridge_on_o === 1'b1, "R3 re-enable on", bridge_on_o, 1);
    cmp_async = 1'b1;
    repeat (3) tick();
    cmp_async = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (bridge_on_o !== 1'b1) bad++;
    end
    check(bad == 0, "R5 blanked pulse ignored", bad, 0);
  endtask

  task automatic t_en_drop();
    int n;
    int bad = 0;
    off_len_cfg = 32'd1000; cmp_async = 1'b1;
    count_until(1'b0, 100, n);
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (bridge_on_o !== 1'b0 || chop_o !== 1'b0) bad++;
    end
    check(bad == 0, "R2 held off while disabled", bad, 0);
    cmp_async = 1'b0;
    tick(); tick();
    en = 1'b1;
    tick();
    check(bridge_on_o === 1'b1, "R10 off time abandoned", bridge_on_o, 1);
    tick();
    en = 1'b0;
    tick();
    check(bridge_on_o === 1'b0, "R2 drop during on", bridge_on_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_enable();
    t_late_cmp();
    t_min_on();
    t_zero_off();
    t_blank();
    t_en_drop();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    #2;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule